// File: doc/BRIEF.md
# Alarm-Armed Periodic Pulse Generator

This block turns a free-running time value into phase-aligned pulse trains, such as one pulse per second. It holds a set of fixed-interval down-counters. Each counter is loaded with a programmed interval. On every accumulator carry strobe it is reduced by the tick period. When it reaches zero it emits a one-clock pulse, and it reloads in the following cycle.

A 64-bit alarm comparator fires once per arming, when the time value is at or beyond the programmed alarm. It records the firing in a sticky status bit. When gating is enabled, the first interval counter stays parked until the alarm fires. Its pulse train then starts on a whole-time boundary chosen by software. The remaining counters always free-run.

When the time value is rewritten, software stops the pulse trains by dropping the timer enable, then writes a new alarm to re-arm the first counter.

Top module: `ivl_pulse_gen`

## Requirements
- R1: After reset all pulse outputs are 0 and the alarm status bit is 0; the alarm is not armed.
- R2: While `tmr_en` is 0, every interval counter reloads its interval from `ivl_cfg`, does not count, and emits no pulse.
- R3: While `tmr_en` is 1, each cycle with `carry` high reduces a running counter by `tick_per`, and a cycle with `carry` low leaves it unchanged. The pulse follows the carry that takes the counter to zero. For interval I and period P, that is carry number ceil(I/P).
- R4: A pulse lasts exactly one clock. In the cycle after it, the counter reloads from `ivl_cfg` and ignores `carry`. With `carry` held high, the pulses repeat every I/P+1 cycles, for example every 9 cycles for I=80, P=10.
- R5: While `tmr_en` is 1 and the alarm is armed, the alarm fires in a cycle where `time_now` is greater than or equal to the alarm value. The status bit is set on the following edge. This covers both equality and overshoot.
- R6: The alarm fires only once per arming. Writing a new value with `alm_wr` re-arms it, and the comparison applies from the cycle after the write.
- R7: `alm_evt` is sticky. A 1 on `alm_clr` clears it, unless the alarm fires in the same cycle, in which case it stays set.
- R8: With `gate_en` set, counter 0 does not count until the alarm fires. It starts counting with the carry of the cycle after the firing.
- R9: Counters 1 and up free-run whatever the alarm and `gate_en` do.
- R10: With `gate_en` set, an `alm_wr` reloads counter 0 and parks it again until the new alarm fires.
- R11: With `gate_en` clear, counter 0 free-runs exactly like the other counters.
- R12: A decrement never goes below zero. A remaining count smaller than `tick_per` becomes zero and pulses: interval 25 with period 10 pulses on every third carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable; low stops and reloads all counters |
| time_now | input | 64 | Current time value |
| carry | input | 1 | Accumulator carry strobe, one per time tick |
| tick_per | input | 8 | Amount removed from a counter per carry |
| ivl_cfg | input | 96 | Intervals, counter k at bits [32k+31:32k] |
| gate_en | input | 1 | Hold counter 0 until the alarm fires |
| alm_wr | input | 1 | Load `alm_val` and arm the alarm |
| alm_val | input | 64 | Alarm time value |
| alm_clr | input | 1 | Write-one clear of the alarm status bit |
| pulse | output | 3 | One-clock pulse per counter, bit k for counter k |
| alm_evt | output | 1 | Sticky alarm status bit |

## Verification
A counter that is off by one tick shows up at the very first pulse. Its pulse arrives one cycle early or late against the ceil(I/P) carry count, and every later pulse is shifted by the same amount, so the bench compares every cycle of each train. An alarm that is wrongly armed, or that fails to disarm, shows on `alm_evt` one edge after the offending cycle. Because the status bit is sticky, the bench clears it and then watches that it stays clear. A broken gate shows at the ports as counter 0 pulsing during the parked window, or as its first pulse after the alarm landing a cycle off its expected position.

// File: rtl/ivl_pkg.sv
package ivl_pkg;

  localparam int unsigned ARITH_W = 64;

  // Saturating subtraction of one tick period from a remaining count.
  function automatic logic [ARITH_W-1:0] ivl_step(input logic [ARITH_W-1:0] remain,
                                                  input logic [ARITH_W-1:0] per);
    return (remain > per) ? (remain - per) : '0;
  endfunction

  // Alarm condition: time has reached or passed the programmed value.
  function automatic logic time_reached(input logic [ARITH_W-1:0] now_t,
                                        input logic [ARITH_W-1:0] target);
    return now_t >= target;
  endfunction

endpackage

// File: rtl/ivl_alarm.sv
module ivl_alarm #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_en,
  input  logic [TIME_W-1:0] time_now,
  input  logic              alm_wr,
  input  logic [TIME_W-1:0] alm_val,
  input  logic              alm_clr,
  output logic              alm_hit,
  output logic              alm_evt
);
  import ivl_pkg::*;

  logic [TIME_W-1:0] target_q;
  logic              armed_q;
  logic              evt_q;

  assign alm_hit = tmr_en & armed_q &
                   time_reached(ARITH_W'(time_now), ARITH_W'(target_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      armed_q  <= 1'b0;
    end else if (alm_wr) begin
      target_q <= alm_val;
      armed_q  <= 1'b1;
    end else if (alm_hit) begin
      armed_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_q <= 1'b0;
    else if (alm_hit) evt_q <= 1'b1;
    else if (alm_clr) evt_q <= 1'b0;
  end

  assign alm_evt = evt_q;
endmodule

// File: rtl/ivl_release.sv
module ivl_release (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  input  logic gate_en,
  input  logic alm_wr,
  input  logic alm_hit,
  output logic hold,
  output logic load
);
  logic released_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       released_q <= 1'b0;
    else if (!tmr_en) released_q <= 1'b0;
    else if (alm_wr)  released_q <= 1'b0;
    else if (alm_hit) released_q <= 1'b1;
  end

  assign hold = gate_en & ~released_q;
  assign load = ~tmr_en | (gate_en & alm_wr);
endmodule

// File: rtl/ivl_downctr.sv
module ivl_downctr #(
  parameter int unsigned IVL_W = 32,
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             carry,
  input  logic [PER_W-1:0] tick_per,
  input  logic [IVL_W-1:0] interval,
  output logic             pulse
);
  import ivl_pkg::*;

  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] cnt_nxt;
  logic             pls_q;

  assign cnt_nxt = IVL_W'(ivl_step(ARITH_W'(cnt_q), ARITH_W'(tick_per)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pls_q <= 1'b0;
    end else if (load || pls_q) begin
      cnt_q <= interval;
      pls_q <= 1'b0;
    end else if (run && carry) begin
      cnt_q <= cnt_nxt;
      pls_q <= (cnt_nxt == '0);
    end
  end

  assign pulse = pls_q;
endmodule

// File: rtl/ivl_pulse_gen.sv
module ivl_pulse_gen #(
  parameter int unsigned N_IVL  = 3,
  parameter int unsigned IVL_W  = 32,
  parameter int unsigned PER_W  = 8,
  parameter int unsigned TIME_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tmr_en,
  input  logic [TIME_W-1:0]      time_now,
  input  logic                   carry,
  input  logic [PER_W-1:0]       tick_per,
  input  logic [N_IVL*IVL_W-1:0] ivl_cfg,
  input  logic                   gate_en,
  input  logic                   alm_wr,
  input  logic [TIME_W-1:0]      alm_val,
  input  logic                   alm_clr,
  output logic [N_IVL-1:0]       pulse,
  output logic                   alm_evt
);
  logic             alm_hit;
  logic             first_hold;
  logic             first_load;
  logic [N_IVL-1:0] ctr_load;
  logic [N_IVL-1:0] ctr_run;

  ivl_alarm #(.TIME_W(TIME_W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_en   (tmr_en),
    .time_now (time_now),
    .alm_wr   (alm_wr),
    .alm_val  (alm_val),
    .alm_clr  (alm_clr),
    .alm_hit  (alm_hit),
    .alm_evt  (alm_evt)
  );

  ivl_release u_release (
    .clk     (clk),
    .rst_n   (rst_n),
    .tmr_en  (tmr_en),
    .gate_en (gate_en),
    .alm_wr  (alm_wr),
    .alm_hit (alm_hit),
    .hold    (first_hold),
    .load    (first_load)
  );

  for (genvar k = 0; k < N_IVL; k++) begin : g_ctr
    if (k == 0) begin : g_gated
      assign ctr_load[k] = first_load;
      assign ctr_run[k]  = tmr_en & ~first_hold;
    end else begin : g_free
      assign ctr_load[k] = ~tmr_en;
      assign ctr_run[k]  = tmr_en;
    end

    ivl_downctr #(.IVL_W(IVL_W), .PER_W(PER_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load[k]),
      .run      (ctr_run[k]),
      .carry    (carry),
      .tick_per (tick_per),
      .interval (ivl_cfg[k*IVL_W +: IVL_W]),
      .pulse    (pulse[k])
    );
  end
endmodule

// File: rtl/ivl_pulse_gen_chk.sv
module ivl_pulse_gen_chk #(
  parameter int unsigned N_IVL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_en,
  input logic             alm_wr,
  input logic             alm_clr,
  input logic             alm_hit,
  input logic             alm_evt,
  input logic             first_hold,
  input logic [N_IVL-1:0] pulse
);
  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> (pulse == '0));

  // R5
  hit_sets_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> alm_evt);

  // R6
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_hit && !alm_wr) |=> !alm_hit);

  // R7
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_evt && !alm_clr) |=> alm_evt);

  // R7
  evt_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_evt) |-> $past(alm_clr));

  // R8
  held_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_hold |=> !pulse[0]);

  for (genvar k = 0; k < N_IVL; k++) begin : g_w
    // R4
    one_clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[k] |=> !pulse[k]);
  end
endmodule

bind ivl_pulse_gen ivl_pulse_gen_chk #(.N_IVL(N_IVL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tmr_en     (tmr_en),
  .alm_wr     (alm_wr),
  .alm_clr    (alm_clr),
  .alm_hit    (alm_hit),
  .alm_evt    (alm_evt),
  .first_hold (first_hold),
  .pulse      (pulse)
);

// File: tb/ivl_pulse_gen_tb.sv
module ivl_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_en = 1'b0;
  logic [63:0] time_now = '0;
  logic        carry = 1'b0;
  logic [7:0]  tick_per = 8'd10;
  logic [95:0] ivl_cfg = '0;
  logic        gate_en = 1'b0;
  logic        alm_wr = 1'b0;
  logic [63:0] alm_val = '0;
  logic        alm_clr = 1'b0;
  logic [2:0]  pulse;
  logic        alm_evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivl_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .time_now(time_now),
    .carry(carry), .tick_per(tick_per), .ivl_cfg(ivl_cfg), .gate_en(gate_en),
    .alm_wr(alm_wr), .alm_val(alm_val), .alm_clr(alm_clr),
    .pulse(pulse), .alm_evt(alm_evt)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse expected at cycle c of a continuous-carry train.
  function automatic bit train_pulse(input int c, input int ivl, input int per);
    int first;
    first = (ivl + per - 1) / per;
    if (first < 1) first = 1;
    return (c >= first) && (((c - first) % (first + 1)) == 0);
  endfunction

  task automatic t_reset();
    check(pulse == 3'b000, "R1 pulses after reset", int'(pulse), 0);
    check(alm_evt == 1'b0, "R1 status after reset", int'(alm_evt), 0);
  endtask

  task automatic t_disabled();
    tmr_en = 1'b0; carry = 1'b1; ivl_cfg = {32'd10, 32'd10, 32'd10};
    for (int c = 0; c < 12; c++) begin
      step();
      check(pulse == 3'b000, "R2 no pulse while disabled", int'(pulse), 0);
    end
  endtask

  task automatic t_trains();
    int ivl [3];
    ivl[0] = 80; ivl[1] = 170; ivl[2] = 25;
    tmr_en = 1'b0; gate_en = 1'b0; tick_per = 8'd10; carry = 1'b1;
    ivl_cfg = {32'(ivl[2]), 32'(ivl[1]), 32'(ivl[0])};
    step();
    tmr_en = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      step();
      for (int k = 0; k < 3; k++) begin
        bit e;
        e = train_pulse(c, ivl[k], 10);
        if (k == 0)      check(pulse[k] == e, "R11 R4 ungated counter 0 train", int'(pulse[k]), int'(e));
        else if (k == 1) check(pulse[k] == e, "R3 R4 counter 1 train", int'(pulse[k]), int'(e));
        else             check(pulse[k] == e, "R12 saturating counter 2 train", int'(pulse[k]), int'(e));
      end
    end
  endtask

  task automatic t_sparse();
    tmr_en = 1'b0; carry = 1'b0; ivl_cfg = {32'd1000, 32'd30, 32'd1000};
    step();
    tmr_en = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      bit e;
      carry = (c % 2) == 1;
      step();
      e = (c == 5) || (c == 11);
      check(pulse[1] == e, "R3 sparse carry counter 1", int'(pulse[1]), int'(e));
    end
    carry = 1'b0;
  endtask

  task automatic t_alarm();
    tmr_en = 1'b1; carry = 1'b0;
    alm_clr = 1'b1; step(); alm_clr = 1'b0;
    alm_val = 64'd1000; alm_wr = 1'b1; time_now = 64'd990; step(); alm_wr = 1'b0;
    time_now = 64'd999; step();
    check(alm_evt == 1'b0, "R5 below alarm", int'(alm_evt), 0);
    time_now = 64'd1000; step();
    check(alm_evt == 1'b1, "R5 equal fires", int'(alm_evt), 1);
    step();
    check(alm_evt == 1'b1, "R7 sticky", int'(alm_evt), 1);
    alm_clr = 1'b1; step(); alm_clr = 1'b0;
    check(alm_evt == 1'b0, "R7 write-one clear", int'(alm_evt), 0);
    time_now = 64'd1005; step(); step();
    check(alm_evt == 1'b0, "R6 fires once per arming", int'(alm_evt), 0);
    alm_val = 64'd500; alm_wr = 1'b1; step(); alm_wr = 1'b0;
    step();
    check(alm_evt == 1'b1, "R6 R5 re-armed past value fires", int'(alm_evt), 1);
    alm_clr = 1'b1; alm_val = 64'd2000; alm_wr = 1'b1; step(); alm_wr = 1'b0;
    check(alm_evt == 1'b0, "R7 cleared before contest", int'(alm_evt), 0);
    time_now = 64'd2000; step(); alm_clr = 1'b0;
    check(alm_evt == 1'b1, "R7 set wins over clear", int'(alm_evt), 1);
    alm_clr = 1'b1; step(); alm_clr = 1'b0;
  endtask

  task automatic t_gate();
    tmr_en = 1'b0; gate_en = 1'b1; tick_per = 8'd10; carry = 1'b1;
    ivl_cfg = {32'd30, 32'd30, 32'd30};
    time_now = 64'd50; alm_val = 64'd100; alm_wr = 1'b1;
    step();
    alm_wr = 1'b0; tmr_en = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      step();
      check(pulse[0] == 1'b0, "R8 counter 0 parked", int'(pulse[0]), 0);
      check(pulse[1] == (c == 3), "R9 counter 1 free-runs", int'(pulse[1]), int'(c == 3));
    end
    time_now = 64'd100;
    step();
    check(alm_evt == 1'b1, "R5 gate alarm fired", int'(alm_evt), 1);
    for (int c = 1; c <= 4; c++) begin
      step();
      check(pulse[0] == (c == 3), "R8 counter 0 starts after alarm", int'(pulse[0]), int'(c == 3));
    end
    alm_val = 64'd10000; alm_wr = 1'b1; step(); alm_wr = 1'b0;
    for (int c = 1; c <= 10; c++) begin
      step();
      check(pulse[0] == 1'b0, "R10 re-armed counter 0 parked", int'(pulse[0]), 0);
    end
    time_now = 64'd10000;
    for (int c = 1; c <= 5; c++) begin
      step();
      check(pulse[0] == (c == 4), "R10 counter 0 resumes at new alarm", int'(pulse[0]), int'(c == 4));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_disabled();
    t_trains();
    t_sparse();
    t_alarm();
    t_gate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule